// File: doc/BRIEF.md
# Power Sign-Change Interrupt Detector

This block watches a stream of signed active-power samples and notices when the sign of the power turns over. A single direction bit chooses which turnover counts. When it is clear, a fall from non-negative to negative power counts. When it is set, a rise from negative to non-negative power counts. A qualifying turnover sets a sticky status flag. The flag stays set until software writes a one to the clear input. A level interrupt is the flag gated by an enable bit.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` is held high out of reset, so every cycle with `s_valid` high accepts one sample. A producer may drop `s_valid` for any number of cycles. While `s_valid` is low the data lines are ignored. The direction and enable bits sit in a small configuration register, which loads from `cfg_dir`/`cfg_irq_en` on a cycle with `cfg_we` high. Both bits reset to 0.

Top module: `psc_sign_irq_top`

## Requirements
- R1: The sign of a sample is its most significant bit, where 1 means negative. A sample of zero, and any positive value, counts as non-negative.
- R2: With the direction bit at 0, an accepted non-negative sample followed by an accepted negative sample sets `status_flag`. The flag is visible in the cycle after the negative sample is accepted.
- R3: With the direction bit at 1, an accepted negative sample followed by an accepted non-negative sample sets `status_flag`. The flag is visible in the cycle after that sample is accepted.
- R4: A sign transition in the direction that is not selected does not set the flag. Two accepted samples of the same sign do not set it either.
- R5: The first accepted sample after reset only records the sign and never sets the flag.
- R6: `irq` is high exactly when `status_flag` is set and the enable bit is 1.
- R7: Once set, `status_flag` stays set until a cycle with `flag_clr` high. After that cycle it reads 0, unless R8 applies.
- R8: When `flag_clr` is high in the same cycle that a qualifying transition is accepted, the flag ends up set.
- R9: After reset, the direction bit and the enable bit are both 0. A cycle with `cfg_we` high loads both bits, and the new values take effect from the next cycle.
- R10: A cycle with `s_valid` low has no effect on the remembered sign, whatever the sample lines carry.
- R11: `s_ready` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready, always 1 |
| s_sample | input | SAMPLE_W | Signed two's complement power sample |
| cfg_we | input | 1 | Load strobe for the configuration bits |
| cfg_dir | input | 1 | Direction to load: 0 = fall to negative, 1 = rise to non-negative |
| cfg_irq_en | input | 1 | Interrupt enable to load |
| flag_clr | input | 1 | Write-one-to-clear for the status flag |
| status_flag | output | 1 | Sticky sign-change flag |
| irq | output | 1 | Level interrupt |

## Verification
Several rules are checked by assertions on every cycle:
- the remembered sign follows each accepted sample and holds when `s_valid` is low;
- a set cannot happen before the first accepted sample;
- the flag holds unless it is cleared;
- set beats clear;
- the interrupt holds until the flag is cleared or the enable changes.

Some behaviour can only be shown by the bench's scenarios against its reference model. This covers the direction choice with zero counted as non-negative, the reset values of the configuration bits as seen through the flag and interrupt, and the rejection of wrong-direction transitions.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic {
    SIGN_NONNEG = 1'b0,
    SIGN_NEG    = 1'b1
  } sign_e;

  typedef struct packed {
    logic dir;
    logic en;
  } cfg_t;
endpackage

// File: rtl/psc_cfg_regs.sv
module psc_cfg_regs
  import psc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic dir_d,
  input  logic en_d,
  output cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.dir <= dir_d;
      cfg_q.en  <= en_d;
    end
  end

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));
endmodule

// File: rtl/psc_sign_track.sv
module psc_sign_track
  import psc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [SAMPLE_W-1:0] sample,
  output sign_e               cur_sign,
  output sign_e               prev_sign,
  output logic                primed
);
  localparam int MSB = SAMPLE_W - 1;

  assign cur_sign = sample[MSB] ? SIGN_NEG : SIGN_NONNEG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sign <= SIGN_NONNEG;
      primed    <= 1'b0;
    end else if (accept) begin
      prev_sign <= cur_sign;
      primed    <= 1'b1;
    end
  end

  assert_prev_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> prev_sign == $past(cur_sign));
  assert_idle_keeps_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(prev_sign) && $stable(primed));
endmodule

// File: rtl/psc_edge_detect.sv
module psc_edge_detect
  import psc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  primed,
  input  sign_e prev_sign,
  input  sign_e cur_sign,
  input  logic  dir,
  output logic  hit
);
  logic falling;
  logic rising;

  assign falling = (prev_sign == SIGN_NONNEG) && (cur_sign == SIGN_NEG);
  assign rising  = (prev_sign == SIGN_NEG) && (cur_sign == SIGN_NONNEG);
  assign hit     = accept && primed && (dir ? rising : falling);

  assert_no_hit_unprimed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !hit);
  assert_hit_needs_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> prev_sign != cur_sign);
endmodule

// File: rtl/psc_status.sv
module psc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set | (flag & ~clr);
  end

  assign irq = flag & en;

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set && clr |=> flag);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> !flag);
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && !set |=> !flag);
endmodule

// File: rtl/psc_sign_irq_top.sv
module psc_sign_irq_top
  import psc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_sample,
  input  logic                cfg_we,
  input  logic                cfg_dir,
  input  logic                cfg_irq_en,
  input  logic                flag_clr,
  output logic                status_flag,
  output logic                irq
);
  cfg_t  cfg;
  sign_e cur_sign;
  sign_e prev_sign;
  logic  primed;
  logic  accept;
  logic  hit;

  assign s_ready = 1'b1;
  assign accept  = s_valid & s_ready;

  psc_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .dir_d (cfg_dir),
    .en_d  (cfg_irq_en),
    .cfg_q (cfg)
  );

  psc_sign_track #(.SAMPLE_W(SAMPLE_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .sample    (s_sample),
    .cur_sign  (cur_sign),
    .prev_sign (prev_sign),
    .primed    (primed)
  );

  psc_edge_detect u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .primed    (primed),
    .prev_sign (prev_sign),
    .cur_sign  (cur_sign),
    .dir       (cfg.dir),
    .hit       (hit)
  );

  psc_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hit),
    .clr   (flag_clr),
    .en    (cfg.en),
    .flag  (status_flag),
    .irq   (irq)
  );

  assert_irq_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !flag_clr && !cfg_we |=> irq);
  assert_first_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !primed && !status_flag |=> !status_flag);
  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready);
endmodule

// File: tb/psc_sign_irq_top_tb_top.sv
`timescale 1ns/1ps
module psc_sign_irq_top_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [W-1:0] s_sample = '0;
  logic         cfg_we = 1'b0;
  logic         cfg_dir = 1'b0;
  logic         cfg_irq_en = 1'b0;
  logic         flag_clr = 1'b0;
  logic         status_flag;
  logic         irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  bit m_prev = 1'b0, m_primed = 1'b0, m_flag = 1'b0, m_dir = 1'b0, m_en = 1'b0;

  always #2 clk = ~clk;

  psc_sign_irq_top #(.SAMPLE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .cfg_we(cfg_we), .cfg_dir(cfg_dir),
    .cfg_irq_en(cfg_irq_en), .flag_clr(flag_clr),
    .status_flag(status_flag), .irq(irq)
  );

  function automatic bit exp_hit(bit v, bit [W-1:0] s, bit prev, bit primed, bit dir);
    bit neg = s[W-1];
    if (!v || !primed) return 1'b0;
    return dir ? (prev && !neg) : (!prev && neg);
  endfunction

  task automatic check(string tag);
    n_vec++;
    if (status_flag !== m_flag) begin
      n_bad++;
      $display("FAIL %s status_flag actual=%b expected=%b", tag, status_flag, m_flag);
    end
    n_vec++;
    if (irq !== (m_flag & m_en)) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_flag & m_en);
    end
    n_vec++;
    if (s_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R11 s_ready actual=%b expected=1", s_ready);
    end
  endtask

  // called at a negedge: drive, model the coming posedge, check at next negedge
  task automatic cyc(bit v, bit [W-1:0] s, bit we, bit d, bit e, bit clr, string tag);
    bit h;
    s_valid = v; s_sample = s; cfg_we = we; cfg_dir = d; cfg_irq_en = e; flag_clr = clr;
    h = exp_hit(v, s, m_prev, m_primed, m_dir);
    m_flag = h | (m_flag & ~clr);
    if (v) begin m_prev = s[W-1]; m_primed = 1'b1; end
    if (we) begin m_dir = d; m_en = e; end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9");                                          // reset state
    cyc(1, 16'h8000, 0, 0, 0, 0, "R5");                   // first sample negative: prime only
    cyc(1, 16'h0000, 0, 0, 0, 0, "R4");                   // neg->zero, dir 0: no set
    cyc(1, 16'hFFFF, 0, 0, 0, 0, "R2");                   // zero->neg sets (R1 zero nonneg), irq 0 since en reset 0 (R9)
    cyc(0, 16'h0000, 1, 0, 1, 0, "R6");                   // enable -> irq visible next cycle
    cyc(0, 16'h0000, 0, 0, 0, 0, "R6");
    repeat (4) cyc(0, 16'h1234, 0, 0, 0, 0, "R7");        // sticky
    cyc(0, 16'h0000, 0, 0, 0, 1, "R7");                   // clear
    cyc(0, 16'h7FFF, 0, 0, 0, 0, "R10");                  // invalid positive ignored
    cyc(1, 16'h8001, 0, 0, 0, 0, "R10");                  // neg after neg: no set
    cyc(1, 16'h8001, 1, 1, 1, 0, "R9");                   // write dir=1
    cyc(1, 16'h0000, 0, 0, 0, 0, "R3");                   // neg->zero sets (R1)
    cyc(0, 16'h0000, 0, 0, 0, 1, "R7");
    cyc(1, 16'h8000, 0, 0, 0, 0, "R4");                   // nonneg->neg, dir 1: no set
    cyc(1, 16'h0001, 0, 0, 0, 1, "R8");                   // set and clear same cycle
    cyc(0, 16'h0000, 0, 0, 0, 0, "R8");
    cyc(1, 16'h4000, 0, 0, 0, 1, "R7");                   // clear, nonneg->nonneg
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 4) != 0;
      bit [W-1:0] s = W'($urandom);
      bit we = ($urandom % 16) == 0;
      bit d = $urandom % 2;
      bit e = $urandom % 2;
      bit clr = ($urandom % 8) == 0;
      string tag;
      if (exp_hit(v, s, m_prev, m_primed, m_dir)) tag = clr ? "R8" : (m_dir ? "R3" : "R2");
      else if (clr) tag = "R7";
      else if (!v) tag = "R10";
      else tag = "R4";
      cyc(v, s, we, d, e, clr, tag);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule